// File: doc/BRIEF.md
# Vsync-Latched Colour Map Converter

This block converts a 4-bit pixel value into 8-bit red, green and blue outputs. The CPU fills a 32-byte colour map through a byte write port with an auto-incrementing index. The map is never used directly by the output path. When a vertical-sync rising edge arrives and something has changed since the last rebuild, a sequencer rebuilds a 16-entry output palette from the map. It spends one clock per entry.

The monitor selection decides how each entry is built. A grey monitor shows the mono nibble as grey. A colour monitor wired with mono on its green gun uses red, mono and blue. A true RGB monitor uses the red, green and blue nibbles. Level codes run inverted through a fixed 16-step table.

After each vertical sync the block can raise a frame interrupt. When a rebuild runs, the interrupt rises only once the last palette entry has been written. The interrupt is a level and stays high until the CPU acknowledges it.

Top module: `vsync_palette_conv`

## Requirements
- R1: A cycle with `idx_load` high loads the write index from `wdata[4:0]`. If `idx_load` is low, a cycle with `map_write` high stores `wdata` at the index and then increments the index modulo 32, so index 31 wraps to 0. `idx_load` wins when both are high. After reset the index is 0.
- R2: Palette entry k (0..15) is built from map byte k and map byte k+16. Byte k holds red in bits 7:4 and green in bits 3:0. Byte k+16 holds mono in bits 7:4 and blue in bits 3:0.
- R3: The level table L maps codes 0..15 to 255, 217, 201, 186, 171, 156, 140, 125, 110, 97, 79, 66, 54, 31, 18, 0. When `mon_sel` is 1 (grey monitor) or 0, all three outputs of an entry equal L[mono].
- R4: When `mon_sel` is 2 (colour monitor), red = G(red nibble), green = G(mono nibble) and blue = G(blue nibble). Here G(n) = floor(17·n·(255−L[n]) / 255).
- R5: When `mon_sel` is 3 (RGB monitor), red = G(red), green = G(green) and blue = G(blue).
- R6: The outputs are a combinational lookup of `pix_idx` in the palette. Map writes and `mon_sel` changes leave the outputs unchanged until a rebuild.
- R7: A rebuild starts only on a `vsync` rising edge while the changed flag is set. The flag is set at reset, by every map write and by every change of `mon_sel`. It is cleared when a rebuild starts, but a write or a selection change in that same cycle keeps it set.
- R8: A rebuild writes entries 0..15 on the 16 clock edges that follow the edge where the `vsync` rise is seen. With `irq_en` high, `irq` rises on the edge that writes entry 15. A `vsync` rise that starts no rebuild sets `irq` on that same edge.
- R9: `irq` stays high until a cycle with `irq_ack` high and no new set. With `irq_en` low, `irq` never rises.
- R10: In reset, `irq` is low and every palette entry reads as zero on all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_load | input | 1 | Load the map write index from wdata |
| map_write | input | 1 | Store wdata into the map and advance the index |
| wdata | input | 8 | CPU write data |
| mon_sel | input | 2 | Monitor selection: 0/1 grey, 2 colour, 3 RGB |
| vsync | input | 1 | Vertical sync, synchronous, rising edge used |
| irq_en | input | 1 | Frame interrupt enable |
| irq_ack | input | 1 | Clears the frame interrupt |
| pix_idx | input | 4 | Pixel value to look up |
| red | output | 8 | Red output for pix_idx |
| green | output | 8 | Green output for pix_idx |
| blue | output | 8 | Blue output for pix_idx |
| irq | output | 1 | Frame interrupt level |

## Verification
The bench builds the block with its default parameters: 4-bit pixels, 8-bit channels and a 32-byte map. At this size every palette entry and every level code can be swept under each of the three monitor selections. The written map makes each nibble field take all 16 codes across the entries, so the whole level table and G function are covered in every mode. The small map also puts the 31-to-0 index wrap and the exact 16-cycle rebuild window within reach. The bench observes that window through the interrupt edge.

// File: rtl/cmap_pkg.sv
// Package: shared constants, monitor-selection encoding and conversion
// functions for the vsync-latched colour map converter.
// Assumes 4-bit level codes; the level table has exactly 16 steps.
package cmap_pkg;

    localparam int PIX_W     = 4;
    localparam int CH_W      = 8;
    localparam int N_ENTRIES = 1 << PIX_W;
    localparam int MAP_BYTES = 2 * N_ENTRIES;
    localparam int MAP_IDX_W = $clog2(MAP_BYTES);

    typedef enum logic [1:0] {
        MON_NONE  = 2'd0,
        MON_GREY  = 2'd1,
        MON_COLOR = 2'd2,
        MON_RGB   = 2'd3
    } mon_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Inverted video level: code 0 is full drive, code 15 is none.
    function automatic logic [7:0] level_of(input logic [3:0] code);
        case (code)
            4'd0:    level_of = 8'd255;
            4'd1:    level_of = 8'd217;
            4'd2:    level_of = 8'd201;
            4'd3:    level_of = 8'd186;
            4'd4:    level_of = 8'd171;
            4'd5:    level_of = 8'd156;
            4'd6:    level_of = 8'd140;
            4'd7:    level_of = 8'd125;
            4'd8:    level_of = 8'd110;
            4'd9:    level_of = 8'd97;
            4'd10:   level_of = 8'd79;
            4'd11:   level_of = 8'd66;
            4'd12:   level_of = 8'd54;
            4'd13:   level_of = 8'd31;
            4'd14:   level_of = 8'd18;
            default: level_of = 8'd0;
        endcase
    endfunction

    // Colour gun drive: nibble scaled to 8 bits and weighted by the level.
    function automatic logic [7:0] gun_of(input logic [3:0] n);
        logic [17:0] prod;
        logic [17:0] quot;
        prod = 18'(17 * 18'(n) * (18'd255 - 18'(level_of(n))));
        quot = prod / 18'd255;
        gun_of = quot[7:0];
    endfunction

endpackage

// File: rtl/cmap_store.sv
// Module: colour map storage with auto-incrementing write index and the
// map-changed flag. Assumes one CPU byte write per cycle at most; an index
// load takes priority over a data write in the same cycle.
module cmap_store
    import cmap_pkg::*;
#(
    parameter int ENTRIES = N_ENTRIES,
    parameter int DW      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       idx_load,
    input  logic                       map_write,
    input  logic [DW-1:0]              wdata,
    input  logic [1:0]                 mon_sel,
    input  logic                       dirty_clr,
    input  logic [$clog2(ENTRIES)-1:0] rd_entry,
    output logic [DW-1:0]              rd_lo,
    output logic [DW-1:0]              rd_hi,
    output logic                       dirty
);
    localparam int BYTES = 2 * ENTRIES;
    localparam int IW    = $clog2(BYTES);
    localparam int EW    = $clog2(ENTRIES);

    logic [DW-1:0] map_q [BYTES];
    logic [IW-1:0] idx_q;
    logic [1:0]    mon_q;
    logic          mon_chg;

    assign mon_chg = (mon_sel != mon_q);

    // Write index: load or post-increment with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_load) begin
            idx_q <= wdata[IW-1:0];
        end else if (map_write) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Map bytes: store CPU data at the current index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) map_q[i] <= '0;
        end else if (map_write && !idx_load) begin
            map_q[idx_q] <= wdata;
        end
    end

    // Changed flag: set by writes and selection changes, cleared at rebuild.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b1;
            mon_q <= 2'd0;
        end else begin
            mon_q <= mon_sel;
            dirty <= (dirty && !dirty_clr) || (map_write && !idx_load) || mon_chg;
        end
    end

    // Read pair for one palette entry: low half and high half of the map.
    assign rd_lo = map_q[{1'b0, rd_entry}];
    assign rd_hi = map_q[{1'b1, rd_entry}];

    logic [EW-1:0] unused_chk;
    assign unused_chk = rd_entry;
endmodule

// File: rtl/cmap_convert.sv
// Module: combinational conversion of one map byte pair into an RGB triple
// for the latched monitor mode. Assumes 4-bit nibbles in 8-bit map bytes.
module cmap_convert
    import cmap_pkg::*;
(
    input  logic [7:0] lo_byte,
    input  logic [7:0] hi_byte,
    input  mon_e       mode,
    output rgb_t       rgb
);
    logic [3:0] n_red, n_grn, n_mono, n_blu;
    logic [7:0] grey;

    assign n_red  = lo_byte[7:4];
    assign n_grn  = lo_byte[3:0];
    assign n_mono = hi_byte[7:4];
    assign n_blu  = hi_byte[3:0];
    assign grey   = level_of(n_mono);

    // Mode select: grey, colour (mono on green) or true RGB.
    always_comb begin
        unique case (mode)
            MON_COLOR: rgb = '{r: gun_of(n_red), g: gun_of(n_mono), b: gun_of(n_blu)};
            MON_RGB:   rgb = '{r: gun_of(n_red), g: gun_of(n_grn),  b: gun_of(n_blu)};
            default:   rgb = '{r: grey, g: grey, b: grey};
        endcase
    end
endmodule

// File: rtl/cmap_reload.sv
// Module: vsync edge detection, palette rebuild sequencer and frame
// interrupt. Assumes vsync is synchronous to clk and that its rising edges
// are more than ENTRIES+1 cycles apart; a rise during a rebuild is ignored.
module cmap_reload
    import cmap_pkg::*;
#(
    parameter int ENTRIES = N_ENTRIES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vsync,
    input  logic                       dirty,
    input  logic                       irq_en,
    input  logic                       irq_ack,
    input  logic [1:0]                 mon_sel,
    output logic                       dirty_clr,
    output logic                       busy,
    output logic [$clog2(ENTRIES)-1:0] wr_idx,
    output mon_e                       mode_q,
    output logic                       irq
);
    localparam int EW = $clog2(ENTRIES);
    localparam logic [EW-1:0] LAST = EW'(ENTRIES - 1);

    logic          vs_q;
    logic          rise;
    logic [EW-1:0] cnt_q;
    logic          last_wr;
    logic          irq_set;

    assign rise      = vsync && !vs_q;
    assign last_wr   = busy && (cnt_q == LAST);
    assign dirty_clr = rise && !busy && dirty;
    assign irq_set   = irq_en && (last_wr || (rise && !busy && !dirty));
    assign wr_idx    = cnt_q;

    // Sequencer: start on a dirty vsync rise, walk every entry once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q   <= 1'b0;
            busy   <= 1'b0;
            cnt_q  <= '0;
            mode_q <= MON_GREY;
        end else begin
            vs_q <= vsync;
            if (busy) begin
                busy  <= !last_wr;
                cnt_q <= last_wr ? '0 : cnt_q + 1'b1;
            end else if (dirty_clr) begin
                busy   <= 1'b1;
                cnt_q  <= '0;
                mode_q <= mon_e'(mon_sel);
            end
        end
    end

    // Frame interrupt: level, set wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (irq_set) begin
            irq <= 1'b1;
        end else if (irq_ack) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/cmap_palette.sv
// Module: output palette registers with one write port and a combinational
// lookup by pixel value. Assumes writes come only from the rebuild sequencer.
module cmap_palette
    import cmap_pkg::*;
#(
    parameter int ENTRIES = N_ENTRIES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  rgb_t                       wr_rgb,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output rgb_t                       rd_rgb
);
    rgb_t pal_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // One palette entry: updated only when the sequencer addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pal_q[e] <= '0;
            end else if (wr_en && (wr_idx == e)) begin
                pal_q[e] <= wr_rgb;
            end
        end
    end

    assign rd_rgb = pal_q[rd_idx];
endmodule

// File: rtl/vsync_palette_conv.sv
// Module: top of the vsync-latched colour map converter. CPU writes fill a
// 32-byte map; a dirty vsync rise rebuilds the 16-entry palette one entry per
// clock; a frame interrupt follows. Assumes synchronous inputs.
module vsync_palette_conv
    import cmap_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int CW = CH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_load,
    input  logic          map_write,
    input  logic [7:0]    wdata,
    input  logic [1:0]    mon_sel,
    input  logic          vsync,
    input  logic          irq_en,
    input  logic          irq_ack,
    input  logic [PW-1:0] pix_idx,
    output logic [CW-1:0] red,
    output logic [CW-1:0] green,
    output logic [CW-1:0] blue,
    output logic          irq
);
    localparam int ENTRIES = 1 << PW;
    localparam int EW      = PW;

    logic          dirty;
    logic          dirty_clr;
    logic          reload_busy;
    logic [EW-1:0] reload_idx;
    mon_e          mode_q;
    logic [7:0]    lo_byte, hi_byte;
    rgb_t          conv_rgb;
    rgb_t          out_rgb;

    cmap_store #(.ENTRIES(ENTRIES), .DW(8)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_load  (idx_load),
        .map_write (map_write),
        .wdata     (wdata),
        .mon_sel   (mon_sel),
        .dirty_clr (dirty_clr),
        .rd_entry  (reload_idx),
        .rd_lo     (lo_byte),
        .rd_hi     (hi_byte),
        .dirty     (dirty)
    );

    cmap_reload #(.ENTRIES(ENTRIES)) u_reload (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .dirty     (dirty),
        .irq_en    (irq_en),
        .irq_ack   (irq_ack),
        .mon_sel   (mon_sel),
        .dirty_clr (dirty_clr),
        .busy      (reload_busy),
        .wr_idx    (reload_idx),
        .mode_q    (mode_q),
        .irq       (irq)
    );

    cmap_convert u_convert (
        .lo_byte (lo_byte),
        .hi_byte (hi_byte),
        .mode    (mode_q),
        .rgb     (conv_rgb)
    );

    cmap_palette #(.ENTRIES(ENTRIES)) u_palette (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reload_busy),
        .wr_idx (reload_idx),
        .wr_rgb (conv_rgb),
        .rd_idx (pix_idx),
        .rd_rgb (out_rgb)
    );

    assign red   = out_rgb.r;
    assign green = out_rgb.g;
    assign blue  = out_rgb.b;
endmodule

// File: rtl/vsync_palette_conv_chk.sv
// Module: checker for the converter, bound to the top module. Watches the
// interrupt protocol, the rebuild start and output stability between rebuilds.
module vsync_palette_conv_chk #(
    parameter int PW = 4,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          irq_en,
    input  logic          irq_ack,
    input  logic [PW-1:0] pix_idx,
    input  logic [CW-1:0] red,
    input  logic [CW-1:0] green,
    input  logic [CW-1:0] blue,
    input  logic          irq,
    input  logic          busy
);
    logic past_ok;

    // Marks cycles that have a valid previous cycle since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq && !irq_ack) |=> irq); // R9

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(irq)) |-> $past(irq_en)); // R9

    AST_REBUILD_ON_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(busy)) |-> $past(vsync)); // R7

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !busy && !$past(busy) && $stable(pix_idx))
            |-> $stable({red, green, blue})); // R6
endmodule

bind vsync_palette_conv vsync_palette_conv_chk #(.PW(PW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync   (vsync),
    .irq_en  (irq_en),
    .irq_ack (irq_ack),
    .pix_idx (pix_idx),
    .red     (red),
    .green   (green),
    .blue    (blue),
    .irq     (irq),
    .busy    (reload_busy)
);

// File: tb/vsync_palette_conv_bench.sv
module vsync_palette_conv_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_load = 1'b0, map_write = 1'b0;
    logic [7:0] wdata = '0;
    logic [1:0] mon_sel = 2'd1;
    logic       vsync = 1'b0, irq_en = 1'b0, irq_ack = 1'b0;
    logic [3:0] pix_idx = '0;
    logic [7:0] red, green, blue;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    logic [7:0] bm [32];

    always #10 clk = ~clk;

    vsync_palette_conv u_vsync_palette_conv (
        .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .map_write(map_write),
        .wdata(wdata), .mon_sel(mon_sel), .vsync(vsync), .irq_en(irq_en),
        .irq_ack(irq_ack), .pix_idx(pix_idx), .red(red), .green(green),
        .blue(blue), .irq(irq)
    );

    function automatic int lvl(input int c);
        case (c)
            0: return 255;  1: return 217;  2: return 201;  3: return 186;
            4: return 171;  5: return 156;  6: return 140;  7: return 125;
            8: return 110;  9: return 97;  10: return 79;  11: return 66;
            12: return 54; 13: return 31;  14: return 18;  default: return 0;
        endcase
    endfunction

    function automatic int gun(input int n);
        return (17 * n * (255 - lvl(n))) / 255;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_idx(input int i);
        @(negedge clk); idx_load = 1'b1; wdata = 8'(i);
        @(negedge clk); idx_load = 1'b0;
    endtask

    task automatic write_byte(input int i, input logic [7:0] d);
        @(negedge clk); map_write = 1'b1; wdata = d;
        bm[i] = d;
        @(negedge clk); map_write = 1'b0;
    endtask

    // Vsync pulse; checks irq timing for a rebuild (R8) or none (R7).
    task automatic vsync_pulse(input bit rebuild, input string req);
        @(negedge clk); vsync = 1'b1;
        if (rebuild) begin
            repeat (16) @(posedge clk);
            @(negedge clk); chk({req, " irq low during rebuild"}, irq, 0);
            @(posedge clk);
            @(negedge clk); chk({req, " irq after last entry"}, irq, irq_en);
        end else begin
            @(posedge clk);
            @(negedge clk); chk({req, " irq on quiet vsync"}, irq, irq_en);
        end
        vsync = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R9 irq cleared by ack", irq, 0);
    endtask

    // Sweep every entry against the bench map model for a given mode.
    task automatic sweep(input int mode, input string req);
        for (int k = 0; k < 16; k++) begin
            int rn, gn, mn, bn, er, eg, eb;
            rn = bm[k][7:4]; gn = bm[k][3:0];
            mn = bm[k+16][7:4]; bn = bm[k+16][3:0];
            if (mode == 2)      begin er = gun(rn); eg = gun(mn); eb = gun(bn); end
            else if (mode == 3) begin er = gun(rn); eg = gun(gn); eb = gun(bn); end
            else                begin er = lvl(mn); eg = er; eb = er; end
            @(negedge clk); pix_idx = 4'(k);
            #1;
            chk({req, " red"}, red, er);
            chk({req, " green"}, green, eg);
            chk({req, " blue"}, blue, eb);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 32; i++) bm[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 irq in reset", irq, 0);
        for (int k = 0; k < 16; k++) begin
            pix_idx = 4'(k); #1;
            chk("R10 palette zero in reset", {red, green, blue}, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: fill map with distinct nibble patterns, sequential index
        load_idx(0);
        for (int k = 0; k < 32; k++) begin
            if (k < 16) write_byte(k, {4'((k + 5) & 15), 4'((k * 3) & 15)});
            else        write_byte(k, {4'(k - 16), 4'(15 - (k - 16))});
        end
        // R6: nothing visible before vsync
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); pix_idx = 4'(k); #1;
            chk("R6 no change before vsync", {red, green, blue}, 0);
        end

        // R3/R8: grey rebuild with interrupt
        irq_en = 1'b1;
        vsync_pulse(1, "R8");
        sweep(1, "R3 grey");
        repeat (3) @(negedge clk);
        chk("R9 irq held without ack", irq, 1);
        ack();

        // R4/R7: selection change alone triggers a rebuild
        mon_sel = 2'd2;
        repeat (2) @(negedge clk);
        sweep(3 - 3 + 1, "R6 old palette kept");
        vsync_pulse(1, "R7 selection change");
        sweep(2, "R4 colour");
        ack();

        // R5: RGB mode
        mon_sel = 2'd3;
        vsync_pulse(1, "R8");
        sweep(3, "R5 rgb");
        ack();

        // R7: quiet vsync does not rebuild
        vsync_pulse(0, "R7");
        ack();

        // R9: disabled interrupt never rises
        irq_en = 1'b0;
        @(negedge clk); vsync = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            chk("R9 irq stays low when disabled", irq, 0);
        end
        vsync = 1'b0;
        irq_en = 1'b1;
        repeat (2) @(negedge clk);

        // R1: wrap from 31 to 0, then rebuild
        load_idx(31);
        write_byte(31, 8'hA5);
        write_byte(0, 8'h3C);
        vsync_pulse(1, "R1 wrap");
        sweep(3, "R1 wrap rgb");
        @(negedge clk); pix_idx = 4'd0; #1;
        chk("R1 byte 0 red after wrap", red, gun(3));
        @(negedge clk); pix_idx = 4'd15; #1;
        chk("R1 byte 31 blue after wrap", blue, gun(5));
        ack();

        // R1: load has priority over write
        @(negedge clk); idx_load = 1'b1; map_write = 1'b1; wdata = 8'd20;
        @(negedge clk); idx_load = 1'b0; map_write = 1'b0;
        write_byte(20, 8'h00);
        vsync_pulse(1, "R1 load priority");
        sweep(3, "R1 load priority rgb");
        ack();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule